// File: doc/BRIEF.md
# Type-C Status Receiver and Lane-Routing Controller

This block sits on a two-wire bus as an I2C target and listens for a status byte from a USB Type-C port controller. The controller writes one byte each time a device is plugged in or pulled out. The block keeps that byte and decodes it into the controls for a DisplayPort crossbar switch: a routing enable, a lane-swap (flip) select, a lane count and a flag that says a display is present.

SCL and SDA are oversampled with the system clock, which must run at least ten times faster than SCL. The target answers one fixed 7-bit address. A write carries an offset byte and then data bytes, and only a byte written to offset 0 is kept. A read returns the stored byte, so the controller can confirm what it wrote. Routing changes only after a complete data byte has been received and acknowledged.

Top module: `tc_route_ctrl`

## Requirements
- R1: The target pulls SDA low (ACK) in the ninth clock of an address byte only when the upper 7 bits equal `TGT_ADDR`. For any other address it leaves SDA released (NACK) and ignores the rest of the transfer.
- R2: In a write, the byte after the address is the register offset, and the target ACKs every byte that follows. A data byte is stored only when the current offset is 0. The offset advances by one after each data byte, and a byte sent to any other offset leaves every output unchanged.
- R3: `dp_attached` and `xbar_en` are 1 only when the stored attach type, bits [6:5], is 2 (4-lane display) or 3 (USB plus 2-lane display). Types 0 (none) and 1 (USB only) give 0.
- R4: `lane_cnt` is 4 for attach type 2, 2 for attach type 3 and 0 otherwise.
- R5: `xbar_flip` follows stored bit 4 (1 = cable flipped) while a display is attached, and is 0 otherwise.
- R6: The outputs take a new byte only at the falling SCL edge that ends the ACK clock of that data byte. While the ACK clock is high they still show the old value. A byte cut off by a STOP has no effect.
- R7: `status_changed` is a one-cycle pulse when a newly stored byte differs from the previous stored byte. Rewriting the same value gives no pulse.
- R8: After reset the stored byte is 0x00, all routing outputs are 0 and SDA is released.
- R9: A read (address with R/W = 1, after a repeated START) returns the stored byte when the offset is 0 and 0x00 for any other offset.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock as seen on the pin |
| sda_in | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| dp_attached | output | 1 | A DisplayPort display is attached |
| xbar_en | output | 1 | Crossbar routing enable |
| xbar_flip | output | 1 | Crossbar lane-swap select for a flipped cable |
| lane_cnt | output | 3 | Active DisplayPort lanes: 0, 2 or 4 |
| status_changed | output | 1 | One-cycle pulse when the stored byte changes |

## Verification
The decoder is driven with status bytes for all four attach types, with the flip bit both set and clear. A 4-lane display and a 2-lane display with flip are told apart by `lane_cnt` and `xbar_flip`. A USB-only device with flip set shows that the flip and routing outputs are gated by the attach type. Writing the same byte twice separates a real change from a rewrite on `status_changed`.

Four bus patterns cover the write path:
- a wrong address, which must be NACKed;
- a nonzero offset, which must be ACKed but not stored;
- a data byte cut off by a STOP, which must not be stored;
- a write followed by a repeated-START read, which checks that the read returns the stored byte.

// File: rtl/tc_route_ctrl.sv
module tc_route_ctrl #(
  parameter logic [6:0] TGT_ADDR = 7'h42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic       dp_attached,
  output logic       xbar_en,
  output logic       xbar_flip,
  output logic [2:0] lane_cnt,
  output logic       status_changed
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_OFFS, S_WDAT, S_ACK, S_RDAT, S_RACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       start_c, stop_c, rise, fall;

  st_t        st, after;
  logic [2:0] cnt;
  logic [7:0] sr, tx, offs, stat, pend;
  logic       byte_rdy, pend_v, mack;
  logic [7:0] txbyte;
  logic [1:0] atype;

  assign scl_s   = scl_sy[1];
  assign sda_s   = sda_sy[1];
  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;
  assign txbyte  = (offs == 8'd0) ? stat : 8'h00;

  assign atype       = stat[6:5];
  assign dp_attached = atype[1];
  assign xbar_en     = atype[1];
  assign xbar_flip   = atype[1] & stat[4];
  assign lane_cnt    = !atype[1] ? 3'd0 : (atype[0] ? 3'd2 : 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      after          <= S_IDLE;
      cnt            <= 3'd0;
      sr             <= 8'h00;
      tx             <= 8'h00;
      offs           <= 8'h00;
      stat           <= 8'h00;
      pend           <= 8'h00;
      byte_rdy       <= 1'b0;
      pend_v         <= 1'b0;
      mack           <= 1'b0;
      sda_oe         <= 1'b0;
      status_changed <= 1'b0;
    end else begin
      status_changed <= 1'b0;
      if (start_c) begin
        st       <= S_ADDR;
        cnt      <= 3'd0;
        byte_rdy <= 1'b0;
        pend_v   <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_c) begin
        st       <= S_IDLE;
        byte_rdy <= 1'b0;
        pend_v   <= 1'b0;
        sda_oe   <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_OFFS, S_WDAT: begin
            if (rise) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) byte_rdy <= 1'b1;
            end else if (fall && byte_rdy) begin
              byte_rdy <= 1'b0;
              case (st)
                S_ADDR: begin
                  if (sr[7:1] == TGT_ADDR) begin
                    sda_oe <= 1'b1;
                    after  <= sr[0] ? S_RDAT : S_OFFS;
                    st     <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                S_OFFS: begin
                  offs   <= sr;
                  sda_oe <= 1'b1;
                  after  <= S_WDAT;
                  st     <= S_ACK;
                end
                default: begin
                  if (offs == 8'd0) begin
                    pend   <= sr;
                    pend_v <= 1'b1;
                  end
                  offs   <= offs + 8'd1;
                  sda_oe <= 1'b1;
                  after  <= S_WDAT;
                  st     <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (fall) begin
              st  <= after;
              cnt <= 3'd0;
              if (pend_v) begin
                stat           <= pend;
                pend_v         <= 1'b0;
                status_changed <= (pend != stat);
              end
              if (after == S_RDAT) begin
                tx     <= txbyte;
                sda_oe <= ~txbyte[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          S_RDAT: begin
            if (fall) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          S_RACK: begin
            if (rise) mack <= ~sda_s;
            else if (fall) begin
              if (mack) begin
                st     <= S_RDAT;
                cnt    <= 3'd0;
                tx     <= txbyte;
                sda_oe <= ~txbyte[7];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tc_route_ctrl_chk.sv
module tc_route_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_q,
  input logic       dp_attached,
  input logic       xbar_flip,
  input logic [2:0] lane_cnt,
  input logic       status_changed
);

  // R7
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_changed |=> !status_changed);

  // R6
  update_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_cnt != $past(lane_cnt) || xbar_flip != $past(xbar_flip)) |-> status_changed);

  // R5
  flip_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xbar_flip |-> dp_attached);

  // R4
  lane_dp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_attached |-> (lane_cnt == 3'd2 || lane_cnt == 3'd4));

  // R4
  lane_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_attached |-> lane_cnt == 3'd0);

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q);

endmodule

bind tc_route_ctrl tc_route_ctrl_chk u_chk (.*);

// File: tb/tc_route_ctrl_bench.sv
module tc_route_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, dp_attached, xbar_en, xbar_flip, status_changed;
  logic [2:0] lane_cnt;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [2:0] snap_lane;
  logic snap_flip;

  always #(CLK_P/2) clk = ~clk;

  tc_route_ctrl #(.TGT_ADDR(ADDR)) u_tc_route_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .dp_attached(dp_attached), .xbar_en(xbar_en), .xbar_flip(xbar_flip),
    .lane_cnt(lane_cnt), .status_changed(status_changed)
  );

  always @(negedge clk) if (status_changed) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    nack = sda_line;
    snap_lane = lane_cnt;
    snap_flip = xbar_flip;
    wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q);
      scl = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] off, input logic [7:0] d,
                    output logic n0, output logic n1, output logic n2);
    i2c_start();
    send_byte({a, 1'b0}, n0);
    n1 = 1'b1; n2 = 1'b1;
    if (!n0) begin
      send_byte(off, n1);
      send_byte(d, n2);
    end
    i2c_stop();
  endtask

  task automatic rd(input logic [7:0] off, output logic [7:0] d);
    logic n;
    i2c_start();
    send_byte({ADDR, 1'b0}, n);
    send_byte(off, n);
    i2c_start();
    send_byte({ADDR, 1'b1}, n);
    chk("R9 read addr ack", n, 0);
    recv_byte(d);
    i2c_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R8 lane_cnt", lane_cnt, 0);
    chk("R8 dp_attached", dp_attached, 0);
    chk("R8 xbar_en", xbar_en, 0);
    chk("R8 xbar_flip", xbar_flip, 0);
    chk("R8 sda_oe", sda_oe, 0);
    rd(8'h00, d);
    chk("R8 stored byte", d, 8'h00);
  endtask

  task automatic t_dp4();
    logic n0, n1, n2;
    int p0 = pulses;
    wr(ADDR, 8'h00, 8'h40, n0, n1, n2);
    chk("R1 addr ack", n0, 0);
    chk("R2 offset ack", n1, 0);
    chk("R2 data ack", n2, 0);
    chk("R6 old lane during ack", snap_lane, 0);
    chk("R4 lane 4", lane_cnt, 4);
    chk("R3 dp_attached", dp_attached, 1);
    chk("R3 xbar_en", xbar_en, 1);
    chk("R5 no flip", xbar_flip, 0);
    chk("R7 pulse", pulses - p0, 1);
  endtask

  task automatic t_dp2_flip();
    logic n0, n1, n2;
    int p0 = pulses;
    wr(ADDR, 8'h00, 8'h70, n0, n1, n2);
    chk("R6 old flip during ack", snap_flip, 0);
    chk("R4 lane 2", lane_cnt, 2);
    chk("R5 flip", xbar_flip, 1);
    chk("R7 pulse", pulses - p0, 1);
  endtask

  task automatic t_same();
    logic n0, n1, n2;
    int p0 = pulses;
    wr(ADDR, 8'h00, 8'h70, n0, n1, n2);
    chk("R7 no pulse on rewrite", pulses - p0, 0);
    chk("R4 lane kept", lane_cnt, 2);
  endtask

  task automatic t_usb_flip();
    logic n0, n1, n2;
    int p0 = pulses;
    wr(ADDR, 8'h00, 8'h30, n0, n1, n2);
    chk("R3 usb only dp", dp_attached, 0);
    chk("R3 usb only xbar_en", xbar_en, 0);
    chk("R5 flip gated", xbar_flip, 0);
    chk("R4 lane 0", lane_cnt, 0);
    chk("R7 pulse", pulses - p0, 1);
    wr(ADDR, 8'h00, 8'h10, n0, n1, n2);
    chk("R3 none attached", dp_attached, 0);
    wr(ADDR, 8'h00, 8'h40, n0, n1, n2);
    chk("R4 back to 4", lane_cnt, 4);
  endtask

  task automatic t_bad_addr();
    logic n0, n1, n2;
    wr(ADDR ^ 7'h01, 8'h00, 8'h70, n0, n1, n2);
    chk("R1 nack", n0, 1);
    chk("R1 lane unchanged", lane_cnt, 4);
  endtask

  task automatic t_offset();
    logic n0, n1, n2;
    logic [7:0] d;
    wr(ADDR, 8'h01, 8'h70, n0, n1, n2);
    chk("R2 data ack at offset 1", n2, 0);
    chk("R2 lane unchanged", lane_cnt, 4);
    chk("R2 flip unchanged", xbar_flip, 0);
    rd(8'h00, d);
    chk("R9 readback", d, 8'h40);
    rd(8'h05, d);
    chk("R9 other offset", d, 8'h00);
  endtask

  task automatic t_abort();
    logic n;
    int p0 = pulses;
    i2c_start();
    send_byte({ADDR, 1'b0}, n);
    send_byte(8'h00, n);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    i2c_stop();
    chk("R6 aborted byte lane", lane_cnt, 4);
    chk("R6 aborted byte pulse", pulses - p0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_dp4();
    t_dp2_flip();
    t_same();
    t_usb_flip();
    t_bad_addr();
    t_offset();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule